// File: doc/BRIEF.md
# Cache-Control Instruction Bus Sequencer

This block accepts one cache-control, ordering or external-access instruction at a time, addressed to one entry of a small array of coherence line states. Each line is in one of five states: Modified, Exclusive, Reserved, Shared or Invalid. From the instruction and the line's present state, a decoder picks the line's next state and the system bus operation to issue, if there is one. An attribute unit computes the write-through (WT) and cache-inhibit (CI) attributes. These come from the page W and I bits, with overrides that depend on the instruction.

When no bus operation is needed, the line is rewritten in the cycle the instruction is accepted. Otherwise a two-state machine moves from `IDLE` to `WAIT` and holds a valid/ready request towards a bus master model. The line is written only on the completing handshake, which moves the machine back to `IDLE`. For a Read, the fill state is taken from a two-bit response returned with `bus_ready`. A combinational peek port shows any line's state.

Top module: `cmaint_seq`

## Requirements
- R1: After reset every line reads Invalid on the peek port, `bus_valid` is 0 and `in_ready` is 1. Line states are encoded M=0, E=1, R=2, S=3, I=4.
- R2: Touch (op 0) on an M, E, R or S line issues nothing and keeps the state. On an I line it issues Read (bus code 1), and the line is then filled per R13.
- R3: Touch-for-store (op 1) on an I line issues RWITM (code 2) when `ext_bus_mode`=0 and RCLAIM (code 3) when it is 1, and the line becomes E. On a valid line it does nothing.
- R4: Zero (op 2) and allocate (op 3) set M or E lines to M with no bus traffic. On R, S or I lines they issue Kill (code 4) and the line becomes M.
- R5: Clean (op 4) on M issues Write-with-kill (code 5) and the line becomes E. On any other state it issues an address-only Clean (code 6) and keeps the state.
- R6: Flush (op 5) on M issues Write-with-kill (code 5). On any other state it issues an address-only Flush (code 7). The line becomes I in both cases.
- R7: Data invalidate (op 6) issues Kill (code 4) and instruction invalidate (op 7) issues code 8. Both leave the line I from any state.
- R8: The state is kept by the following ops, each issuing its own code: TLB sync (op 8, code 9), ordering barrier (op 9, code 10), external read (op 10, code 11) and external write (op 11, code 12).
- R9: `bus_wt` is 1 for Write-with-kill pushes and for external reads, and 0 for external writes. For every other operation it is the inverse of `page_w`.
- R10: `bus_ci` is 1 for external reads and writes. It is also 1 for the data-access ops (0 to 3) while `dcache_off`=1. Otherwise it is the inverse of `page_i`.
- R11: While a request is held, the line keeps its old state, and `bus_op`, `bus_index`, `bus_wt` and `bus_ci` stay stable until `bus_ready`. The line is written at the completing edge.
- R12: While a request is outstanding, `in_ready` is 0 and any presented instruction has no effect.
- R13: The fill state of a Read depends on `bus_fill`: 0 gives E, 1 gives S, and 2 or 3 give R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Sequencer can accept (IDLE) |
| in_op | input | 4 | Instruction code |
| in_index | input | IDX_W | Target line index |
| page_w | input | 1 | Page write-through bit |
| page_i | input | 1 | Page cache-inhibit bit |
| dcache_off | input | 1 | L1 data cache disabled |
| ext_bus_mode | input | 1 | 1 selects the extended bus opcode set |
| bus_valid | output | 1 | Bus request held |
| bus_ready | input | 1 | Bus operation completes |
| bus_op | output | 4 | Bus operation code |
| bus_index | output | IDX_W | Line index of the request |
| bus_wt | output | 1 | Write-through attribute |
| bus_ci | output | 1 | Cache-inhibit attribute |
| bus_fill | input | 2 | Fill state response for Read |
| peek_index | input | IDX_W | Line to observe |
| peek_state | output | 3 | State of the observed line |

## Verification
The bench runs all twelve instructions against all five prepared line states, once in each bus mode. The page bits, the data-cache-disable bit and the fill response cycle through their values, so the decode table, the opcode choice between bus modes, the attribute overrides and the fill mapping are all separated from one another. Each request is held for two cycles before completion, which exposes any early state write or any drift in the request. A separate scenario presents an instruction while a request is outstanding, to show that it is blocked without side effects.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
    typedef enum logic [2:0] {
        LS_M = 3'd0, LS_E = 3'd1, LS_R = 3'd2, LS_S = 3'd3, LS_I = 3'd4
    } line_st_t;

    typedef enum logic [3:0] {
        IN_TOUCH = 4'd0, IN_TOUCHST = 4'd1, IN_ZERO = 4'd2, IN_ALLOC = 4'd3,
        IN_CLEAN = 4'd4, IN_FLUSH = 4'd5, IN_INVAL = 4'd6, IN_IINVAL = 4'd7,
        IN_TSYNC = 4'd8, IN_ORDER = 4'd9, IN_EXTRD = 4'd10, IN_EXTWR = 4'd11
    } instr_t;

    typedef enum logic [3:0] {
        BO_NONE = 4'd0, BO_READ = 4'd1, BO_RWITM = 4'd2, BO_RCLAIM = 4'd3,
        BO_KILL = 4'd4, BO_WWK = 4'd5, BO_CLEAN = 4'd6, BO_FLUSH = 4'd7,
        BO_ICBI = 4'd8, BO_TSYNC = 4'd9, BO_EIEIO = 4'd10, BO_EXTRD = 4'd11,
        BO_EXTWR = 4'd12
    } busop_t;

    typedef struct packed {
        busop_t   op;
        line_st_t nxt;
        logic     fill;
        logic     push;
        logic     data_acc;
    } dec_t;
endpackage

// File: rtl/cmaint_decode.sv
module cmaint_decode
    import cmaint_pkg::*;
(
    input  instr_t   op,
    input  line_st_t cur,
    input  logic     ext_mode,
    output dec_t     dec
);
    logic valid_line;
    assign valid_line = (cur != LS_I);

    always_comb begin
        dec.op       = BO_NONE;
        dec.nxt      = cur;
        dec.fill     = 1'b0;
        dec.push     = 1'b0;
        dec.data_acc = 1'b0;
        case (op)
            IN_TOUCH: begin
                dec.data_acc = 1'b1;
                if (!valid_line) begin
                    dec.op   = BO_READ;
                    dec.fill = 1'b1;
                end
            end
            IN_TOUCHST: begin
                dec.data_acc = 1'b1;
                if (!valid_line) begin
                    if (ext_mode) dec.op = BO_RCLAIM;
                    else          dec.op = BO_RWITM;
                    dec.nxt = LS_E;
                end
            end
            IN_ZERO, IN_ALLOC: begin
                dec.data_acc = 1'b1;
                dec.nxt      = LS_M;
                if (cur != LS_M && cur != LS_E) dec.op = BO_KILL;
            end
            IN_CLEAN: begin
                if (cur == LS_M) begin
                    dec.op   = BO_WWK;
                    dec.push = 1'b1;
                    dec.nxt  = LS_E;
                end else begin
                    dec.op = BO_CLEAN;
                end
            end
            IN_FLUSH: begin
                dec.nxt = LS_I;
                if (cur == LS_M) begin
                    dec.op   = BO_WWK;
                    dec.push = 1'b1;
                end else begin
                    dec.op = BO_FLUSH;
                end
            end
            IN_INVAL: begin
                dec.op  = BO_KILL;
                dec.nxt = LS_I;
            end
            IN_IINVAL: begin
                dec.op  = BO_ICBI;
                dec.nxt = LS_I;
            end
            IN_TSYNC: dec.op = BO_TSYNC;
            IN_ORDER: dec.op = BO_EIEIO;
            IN_EXTRD: dec.op = BO_EXTRD;
            IN_EXTWR: dec.op = BO_EXTWR;
            default:  dec.op = BO_NONE;
        endcase
    end
endmodule

// File: rtl/cmaint_attr.sv
module cmaint_attr
    import cmaint_pkg::*;
(
    input  instr_t op,
    input  logic   push,
    input  logic   data_acc,
    input  logic   page_w,
    input  logic   page_i,
    input  logic   dc_off,
    output logic   wt,
    output logic   ci
);
    always_comb begin
        if (push || op == IN_EXTRD) wt = 1'b1;
        else if (op == IN_EXTWR)    wt = 1'b0;
        else                        wt = ~page_w;

        if (op == IN_EXTRD || op == IN_EXTWR) ci = 1'b1;
        else if (data_acc && dc_off)          ci = 1'b1;
        else                                  ci = ~page_i;
    end
endmodule

// File: rtl/cmaint_lines.sv
module cmaint_lines
    import cmaint_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_st,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_t         rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_t         rd_b_st
);
    line_st_t st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  st_q[g] <= LS_I;
            else if (wr_en && wr_idx == IDX_W'(g))       st_q[g] <= wr_st;
        end
    end

    assign rd_a_st = st_q[rd_a_idx];
    assign rd_b_st = st_q[rd_b_idx];

    p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_st <= LS_I));
endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       in_op,
    input  logic [IDX_W-1:0] in_index,
    input  logic             page_w,
    input  logic             page_i,
    input  logic             dcache_off,
    input  logic             ext_bus_mode,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic [3:0]       bus_op,
    output logic [IDX_W-1:0] bus_index,
    output logic             bus_wt,
    output logic             bus_ci,
    input  logic [1:0]       bus_fill,
    input  logic [IDX_W-1:0] peek_index,
    output logic [2:0]       peek_state
);
    typedef enum logic {S_IDLE, S_WAIT} fsm_t;

    fsm_t             fsm_q, fsm_d;
    line_st_t         cur_st, peek_st, wr_st, fill_st;
    dec_t             dec;
    logic             wt_c, ci_c, accept, done, wr_en;
    logic [IDX_W-1:0] wr_idx;
    busop_t           pend_op;
    line_st_t         pend_nxt;
    logic             pend_fill;

    cmaint_lines #(.LINES(LINES)) u_lines (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
        .rd_a_idx(in_index), .rd_a_st(cur_st),
        .rd_b_idx(peek_index), .rd_b_st(peek_st)
    );

    cmaint_decode u_dec (
        .op(instr_t'(in_op)), .cur(cur_st), .ext_mode(ext_bus_mode), .dec(dec)
    );

    cmaint_attr u_attr (
        .op(instr_t'(in_op)), .push(dec.push), .data_acc(dec.data_acc),
        .page_w(page_w), .page_i(page_i), .dc_off(dcache_off),
        .wt(wt_c), .ci(ci_c)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= S_IDLE;
        else        fsm_q <= fsm_d;
    end

    // Transitions: IDLE->WAIT on an accepted instruction that needs the bus,
    // WAIT->IDLE on the completing handshake.
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            S_IDLE: if (accept && dec.op != BO_NONE) fsm_d = S_WAIT;
            S_WAIT: if (bus_ready)                   fsm_d = S_IDLE;
        endcase
    end

    // Captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_op   <= BO_NONE;
            pend_nxt  <= LS_I;
            pend_fill <= 1'b0;
            bus_index <= '0;
            bus_wt    <= 1'b0;
            bus_ci    <= 1'b0;
        end else if (accept && dec.op != BO_NONE) begin
            pend_op   <= dec.op;
            pend_nxt  <= dec.nxt;
            pend_fill <= dec.fill;
            bus_index <= in_index;
            bus_wt    <= wt_c;
            bus_ci    <= ci_c;
        end
    end

    // Outputs and line write
    always_comb begin
        in_ready   = (fsm_q == S_IDLE);
        bus_valid  = (fsm_q == S_WAIT);
        bus_op     = bus_valid ? pend_op : BO_NONE;
        accept     = in_valid && in_ready;
        done       = bus_valid && bus_ready;
        peek_state = peek_st;
        unique case (bus_fill)
            2'd0:    fill_st = LS_E;
            2'd1:    fill_st = LS_S;
            default: fill_st = LS_R;
        endcase
        wr_en  = (accept && dec.op == BO_NONE) || done;
        wr_idx = done ? bus_index : in_index;
        if (done) wr_st = pend_fill ? fill_st : pend_nxt;
        else      wr_st = dec.nxt;
    end

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_op) &&
        $stable(bus_index) && $stable(bus_wt) && $stable(bus_ci)));
    p_req_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_op != BO_NONE));
    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !in_ready);
    p_push_wt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_op == BO_WWK) |-> bus_wt);
    p_ext_ci_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_op == BO_EXTRD || bus_op == BO_EXTWR)) |-> bus_ci);
endmodule

// File: tb/cmaint_seq_tb.sv
module cmaint_seq_tb;
    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_ready, page_w = 0, page_i = 0, dcache_off = 0, ext_bus_mode = 0;
    logic [3:0] in_op = 0;
    logic [IDX_W-1:0] in_index = 0, bus_index, peek_index = 0;
    logic bus_valid, bus_ready = 0, bus_wt, bus_ci;
    logic [3:0] bus_op;
    logic [1:0] bus_fill = 0;
    logic [2:0] peek_state;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmaint_seq #(.LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_index(in_index), .page_w(page_w), .page_i(page_i),
        .dcache_off(dcache_off), .ext_bus_mode(ext_bus_mode),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op),
        .bus_index(bus_index), .bus_wt(bus_wt), .bus_ci(bus_ci),
        .bus_fill(bus_fill), .peek_index(peek_index), .peek_state(peek_state)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";  1: return "R3";  2, 3: return "R4";
            4: return "R5";  5: return "R6";  6, 7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model written from the requirements
    function automatic int exp_bus(input int op, input int st, input bit mode);
        case (op)
            0: return (st == 4) ? 1 : 0;
            1: return (st == 4) ? (mode ? 3 : 2) : 0;
            2, 3: return (st <= 1) ? 0 : 4;
            4: return (st == 0) ? 5 : 6;
            5: return (st == 0) ? 5 : 7;
            6: return 4;
            7: return 8;
            default: return op + 1;
        endcase
    endfunction

    function automatic int exp_next(input int op, input int st, input int fill);
        case (op)
            0: return (st == 4) ? ((fill == 0) ? 1 : (fill == 1) ? 3 : 2) : st;
            1: return (st == 4) ? 1 : st;
            2, 3: return 0;
            4: return (st == 0) ? 1 : st;
            5, 6, 7: return 4;
            default: return st;
        endcase
    endfunction

    function automatic bit exp_wt(input int op, input int bop, input bit w);
        if (bop == 5 || op == 10) return 1'b1;
        if (op == 11) return 1'b0;
        return ~w;
    endfunction

    function automatic bit exp_ci(input int op, input bit i, input bit dco);
        if (op == 10 || op == 11) return 1'b1;
        if (op <= 3 && dco) return 1'b1;
        return ~i;
    endfunction

    task automatic issue(input int op, input int idx);
        @(negedge clk);
        in_op = 4'(op); in_index = IDX_W'(idx); in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic complete(input int fill);
        @(negedge clk);
        bus_ready = 1'b1; bus_fill = 2'(fill);
        @(posedge clk); #1;
        bus_ready = 1'b0;
    endtask

    task automatic prep(input int idx, input int st);
        issue(6, idx); complete(0);
        case (st)
            0: begin issue(0, idx); complete(0); issue(2, idx); end
            1: begin issue(0, idx); complete(0); end
            2: begin issue(0, idx); complete(2); end
            3: begin issue(0, idx); complete(1); end
            default: ;
        endcase
    endtask

    task automatic test_reset();
        for (int k = 0; k < LINES; k++) begin
            peek_index = IDX_W'(k); #1;
            chk(peek_state == 3'd4, "R1", "line state after reset", peek_state, 4);
        end
        chk(bus_valid == 1'b0, "R1", "bus_valid after reset", bus_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic run_pair(input int op, input int st, input bit mode, input int k);
        int idx = (op + st) % LINES;
        int eb, en, fill;
        bit w, i, dco;
        w = k[0]; i = k[1]; dco = k[2]; fill = k % 3;
        prep(idx, st);
        page_w = w; page_i = i; dcache_off = dco; ext_bus_mode = mode;
        peek_index = IDX_W'(idx);
        eb = exp_bus(op, st, mode);
        en = exp_next(op, st, fill);
        issue(op, idx);
        if (eb != 0) begin
            chk(bus_valid == 1'b1, req_of(op), "bus_valid", bus_valid, 1);
            chk(int'(bus_op) == eb, req_of(op), "bus_op", bus_op, eb);
            chk(int'(bus_index) == idx, "R11", "bus_index", bus_index, idx);
            chk(bus_wt == exp_wt(op, eb, w), "R9", "bus_wt", bus_wt, exp_wt(op, eb, w));
            chk(bus_ci == exp_ci(op, i, dco), "R10", "bus_ci", bus_ci, exp_ci(op, i, dco));
            repeat (2) @(posedge clk);
            #1;
            chk(int'(peek_state) == st, "R11", "state before handshake", peek_state, st);
            chk(bus_valid && int'(bus_op) == eb, "R11", "request held", bus_op, eb);
            complete(fill);
            chk(bus_valid == 1'b0, "R11", "request dropped", bus_valid, 0);
            if (op == 0) chk(int'(peek_state) == en, "R13", "fill state", peek_state, en);
        end else begin
            chk(bus_valid == 1'b0, req_of(op), "no bus request", bus_valid, 0);
        end
        chk(int'(peek_state) == en, req_of(op), "next state", peek_state, en);
    endtask

    task automatic test_table();
        int k = 0;
        for (int m = 0; m < 2; m++)
            for (int op = 0; op < 12; op++)
                for (int st = 0; st < 5; st++) begin
                    run_pair(op, st, bit'(m), k);
                    k++;
                end
    endtask

    task automatic test_busy();
        prep(5, 1);
        prep(6, 1);
        issue(4, 5);
        @(negedge clk);
        in_op = 4'd6; in_index = IDX_W'(6); in_valid = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(in_ready == 1'b0, "R12", "in_ready while busy", in_ready, 0);
        chk(int'(bus_op) == 6 && int'(bus_index) == 5, "R12", "request unchanged", bus_op, 6);
        @(negedge clk); in_valid = 1'b0;
        complete(0);
        peek_index = IDX_W'(6); #1;
        chk(int'(peek_state) == 1, "R12", "blocked line untouched", peek_state, 1);
        chk(in_ready == 1'b1, "R12", "ready after completion", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        test_table();
        test_busy();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule